// File: doc/BRIEF.md
# Multi-Output Digital PWM Generator

This block drives a bank of gate-control outputs from a shared period counter. The counter advances at a rate picked by a two-bit speed code: every clock, every fourth clock or every eighth clock. Each output has its own rising-edge compare value. Its falling-edge value is an offset plus a common duty command. This lets one duty word steer complementary or dead-time-separated pairs. The duty word and all edge values are captured into shadow registers only when a new period begins. A change made in the middle of a period therefore never tears a pulse.

A period starts when the counter passes the programmed last count. It also starts on a qualified rising edge of an external sync input, so several generators can share one switching frequency.

Several overrides sit above normal modulation, in this order from strongest to weakest:
- An over-current fault forces the outputs to one stop vector.
- An inactive enable, with programmable polarity, forces a second stop vector.
- A software bypass pins chosen outputs to given levels.
- A terminate request from the current limiter pulls the remaining outputs low until the period ends.

Top module: `mpwm_top`

## Requirements
- R1: The period counter advances once per clock for speed code 00, once per 4 clocks for 01, and once per 8 clocks for 10 and 11. A period lasts (periodLen+1) counter steps, so `cycleStart` pulses every (periodLen+1)·divider clocks.
- R2: A 0→1 transition on `syncIn`, seen at counter steps, restarts the period at that step. This happens only if `syncIn` was low at the 3 preceding counter steps. After only 2 low steps the transition has no effect on the period.
- R3: When `enableIn` differs from `enablePol` (and no fault is present), every output equals the corresponding bit of `stopDis`. This applies for both polarity settings.
- R4: While `ocpFault` is high, every output equals the corresponding bit of `stopOcp`, regardless of enable, bypass or terminate.
- R5: With the block enabled and no fault, an output whose `bypassSel` bit is 1 equals its `bypassVal` bit. Unselected outputs keep modulating, and bypassed outputs ignore terminate.
- R6: A `termReq` pulse drives all non-bypassed outputs low from the following clock edge until the end of the current period. The next period modulates normally.
- R7: In normal modulation, output i is high while rise_i ≤ count < fall_i + duty. The sum is formed one bit wider than the count and does not wrap. Field i of `riseOfs`/`fallOfs` occupies bits [i·CNT_W +: CNT_W].
- R8: Changes to `dutyCmd`, `riseOfs` or `fallOfs` take effect only from the next period start.
- R9: `cycleStart` is high for one clock when the count returns to zero. Each output reflects the count of the previous clock.
- R10: During reset all outputs and `cycleStart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedSel | input | 2 | Counter rate code |
| periodLen | input | CNT_W | Last count of a period |
| dutyCmd | input | CNT_W | Duty command added to every fall edge |
| riseOfs | input | NUM_OUT·CNT_W | Per-output rise compare values |
| fallOfs | input | NUM_OUT·CNT_W | Per-output fall offsets |
| syncIn | input | 1 | External period synchronization |
| enableIn | input | 1 | Supply on/off input |
| enablePol | input | 1 | Level of `enableIn` that means enabled |
| ocpFault | input | 1 | Over-current shutdown request |
| termReq | input | 1 | Current-limit terminate request |
| bypassSel | input | NUM_OUT | Outputs under software override |
| bypassVal | input | NUM_OUT | Override levels |
| stopDis | input | NUM_OUT | Output vector while disabled |
| stopOcp | input | NUM_OUT | Output vector during a fault |
| phOut | output | NUM_OUT | Gate-control outputs |
| cycleStart | output | 1 | One-clock period start strobe |

## Verification
The outputs are registered, so a change on a level input is visible one clock edge after it is applied. This covers fault, enable, bypass and terminate. The bench samples on the falling edge after that rising edge.

The counter is also registered. At full speed, the sample k falling edges after a `cycleStart` therefore reflects count k−1. The bench indexes its arithmetic model that way, and expects the next `cycleStart` exactly periodLen+1 samples later.

A sync edge applied after three low steps shows up as `cycleStart` on the very next sample. Prescaled periods are checked by counting clocks between two strobes, after letting one full period pass under the new speed code.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic [1:0] {
    SPD_FULL  = 2'b00,
    SPD_DIV4  = 2'b01,
    SPD_DIV8  = 2'b10,
    SPD_DIV8B = 2'b11
  } speedCode_e;

  localparam int PRE_W = 3;

  typedef struct packed {
    logic loadShadow;
    logic clearTerm;
  } pwmStrobe_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int SYNC_MIN_LOW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       speedSel,
  input  logic [CNT_W-1:0] periodLen,
  input  logic             syncIn,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobe,
  output logic             cycleStart
);
  localparam int LOW_W = $clog2(SYNC_MIN_LOW + 1);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(SYNC_MIN_LOW);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic             tick;
  logic             syncPrev;
  logic [LOW_W-1:0] lowCnt;
  logic             syncGo;
  logic             periodStart;

  always_comb begin
    case (speedCode_e'(speedSel))
      SPD_FULL: preLast = '0;
      SPD_DIV4: preLast = PRE_W'(3);
      default:  preLast = PRE_W'(7);
    endcase
  end

  assign tick        = (preCnt >= preLast);
  assign syncGo      = tick && syncIn && !syncPrev && (lowCnt == LOW_SAT);
  assign periodStart = tick && (syncGo || (cnt >= periodLen));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      lowCnt   <= '0;
    end else if (tick) begin
      syncPrev <= syncIn;
      if (syncIn) begin
        lowCnt <= '0;
      end else if (lowCnt != LOW_SAT) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      cycleStart <= 1'b0;
    end else begin
      cycleStart <= periodStart;
      if (periodStart) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe.loadShadow = periodStart;
  assign strobe.clearTerm  = periodStart;
endmodule

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int CNT_W   = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         cnt,
  input  pwmStrobe_t               strobe,
  input  logic [CNT_W-1:0]         dutyCmd,
  input  logic [NUM_OUT*CNT_W-1:0] riseOfs,
  input  logic [NUM_OUT*CNT_W-1:0] fallOfs,
  input  logic                     termReq,
  input  logic                     enableIn,
  input  logic                     enablePol,
  input  logic                     ocpFault,
  input  logic [NUM_OUT-1:0]       bypassSel,
  input  logic [NUM_OUT-1:0]       bypassVal,
  input  logic [NUM_OUT-1:0]       stopDis,
  input  logic [NUM_OUT-1:0]       stopOcp,
  output logic [NUM_OUT-1:0]       phOut
);
  logic [CNT_W-1:0]   dutyShadow;
  logic               termHold;
  logic               terminated;
  logic               enActive;
  logic [NUM_OUT-1:0] nextOut;

  assign enActive   = (enableIn == enablePol);
  assign terminated = termReq || termHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyShadow <= '0;
    end else if (strobe.loadShadow) begin
      dutyShadow <= dutyCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      termHold <= 1'b0;
    end else if (strobe.clearTerm) begin
      termHold <= 1'b0;
    end else if (termReq) begin
      termHold <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    logic [CNT_W-1:0] riseShadow;
    logic [CNT_W-1:0] fallShadow;
    logic [CNT_W:0]   fallEnd;
    logic             pulseOn;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseShadow <= '0;
        fallShadow <= '0;
      end else if (strobe.loadShadow) begin
        riseShadow <= riseOfs[g*CNT_W +: CNT_W];
        fallShadow <= fallOfs[g*CNT_W +: CNT_W];
      end
    end

    assign fallEnd = {1'b0, fallShadow} + {1'b0, dutyShadow};
    assign pulseOn = (cnt >= riseShadow) && ({1'b0, cnt} < fallEnd);

    assign nextOut[g] = ocpFault     ? stopOcp[g]   :
                        !enActive    ? stopDis[g]   :
                        bypassSel[g] ? bypassVal[g] :
                        terminated   ? 1'b0         :
                                       pulseOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phOut <= '0;
    end else begin
      phOut <= nextOut;
    end
  end
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int CNT_W   = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               speedSel,
  input  logic [CNT_W-1:0]         periodLen,
  input  logic [CNT_W-1:0]         dutyCmd,
  input  logic [NUM_OUT*CNT_W-1:0] riseOfs,
  input  logic [NUM_OUT*CNT_W-1:0] fallOfs,
  input  logic                     syncIn,
  input  logic                     enableIn,
  input  logic                     enablePol,
  input  logic                     ocpFault,
  input  logic                     termReq,
  input  logic [NUM_OUT-1:0]       bypassSel,
  input  logic [NUM_OUT-1:0]       bypassVal,
  input  logic [NUM_OUT-1:0]       stopDis,
  input  logic [NUM_OUT-1:0]       stopOcp,
  output logic [NUM_OUT-1:0]       phOut,
  output logic                     cycleStart
);
  logic [CNT_W-1:0] cnt;
  pwmStrobe_t       strobe;

  mpwm_ctrl #(.CNT_W(CNT_W), .SYNC_MIN_LOW(3)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .speedSel   (speedSel),
    .periodLen  (periodLen),
    .syncIn     (syncIn),
    .cnt        (cnt),
    .strobe     (strobe),
    .cycleStart (cycleStart)
  );

  mpwm_datapath #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cnt       (cnt),
    .strobe    (strobe),
    .dutyCmd   (dutyCmd),
    .riseOfs   (riseOfs),
    .fallOfs   (fallOfs),
    .termReq   (termReq),
    .enableIn  (enableIn),
    .enablePol (enablePol),
    .ocpFault  (ocpFault),
    .bypassSel (bypassSel),
    .bypassVal (bypassVal),
    .stopDis   (stopDis),
    .stopOcp   (stopOcp),
    .phOut     (phOut)
  );
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker #(
  parameter int NUM_OUT = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         speedSel,
  input logic               enableIn,
  input logic               enablePol,
  input logic               ocpFault,
  input logic               termReq,
  input logic [NUM_OUT-1:0] bypassSel,
  input logic [NUM_OUT-1:0] bypassVal,
  input logic [NUM_OUT-1:0] stopDis,
  input logic [NUM_OUT-1:0] stopOcp,
  input logic [NUM_OUT-1:0] phOut,
  input logic               cycleStart
);
  AST_OCP_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ocpFault |=> (phOut == $past(stopOcp)));  // R4

  AST_DIS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (!ocpFault && (enableIn != enablePol)) |=> (phOut == $past(stopDis)));  // R3

  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ocpFault && (enableIn == enablePol))
      |=> (((phOut ^ $past(bypassVal)) & $past(bypassSel)) == '0));  // R5

  AST_TERM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!ocpFault && (enableIn == enablePol) && termReq)
      |=> ((phOut & ~$past(bypassSel)) == '0));  // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && (speedSel != 2'b00))
      |=> (!cycleStart || (speedSel == 2'b00)));  // R9
endmodule

bind mpwm_top mpwm_checker #(.NUM_OUT(NUM_OUT)) u_mpwm_chk (
  .clk        (clk),
  .rstN       (rstN),
  .speedSel   (speedSel),
  .enableIn   (enableIn),
  .enablePol  (enablePol),
  .ocpFault   (ocpFault),
  .termReq    (termReq),
  .bypassSel  (bypassSel),
  .bypassVal  (bypassVal),
  .stopDis    (stopDis),
  .stopOcp    (stopOcp),
  .phOut      (phOut),
  .cycleStart (cycleStart)
);

// File: tb/test_mpwm_top.sv
`timescale 1ns/1ps
module test_mpwm_top;
  localparam int NO = 6;
  localparam int CW = 9;
  localparam int P  = 15;

  logic           clk = 1'b0;
  logic           rstN;
  logic [1:0]     speedSel;
  logic [CW-1:0]  periodLen;
  logic [CW-1:0]  dutyCmd;
  logic [NO*CW-1:0] riseOfs;
  logic [NO*CW-1:0] fallOfs;
  logic           syncIn, enableIn, enablePol, ocpFault, termReq;
  logic [NO-1:0]  bypassSel, bypassVal, stopDis, stopOcp;
  logic [NO-1:0]  phOut;
  logic           cycleStart;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int riseB [NO];
  int fallB [NO];
  int dutyB;
  int actRise [NO];
  int actFall [NO];
  int actDuty;

  always #5 clk = ~clk;

  mpwm_top #(.NUM_OUT(NO), .CNT_W(CW)) i_mpwm_top (
    .clk(clk), .rstN(rstN), .speedSel(speedSel), .periodLen(periodLen),
    .dutyCmd(dutyCmd), .riseOfs(riseOfs), .fallOfs(fallOfs), .syncIn(syncIn),
    .enableIn(enableIn), .enablePol(enablePol), .ocpFault(ocpFault),
    .termReq(termReq), .bypassSel(bypassSel), .bypassVal(bypassVal),
    .stopDis(stopDis), .stopOcp(stopOcp), .phOut(phOut), .cycleStart(cycleStart)
  );

  task automatic chk(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic drivePorts();
    for (int i = 0; i < NO; i++) begin
      riseOfs[i*CW +: CW] = CW'(riseB[i]);
      fallOfs[i*CW +: CW] = CW'(fallB[i]);
    end
    dutyCmd = CW'(dutyB);
  endtask

  task automatic latchActive();
    for (int i = 0; i < NO; i++) begin
      actRise[i] = riseB[i];
      actFall[i] = fallB[i];
    end
    actDuty = dutyB;
  endtask

  function automatic logic [NO-1:0] expVec(input int c, input bit term);
    logic [NO-1:0] v;
    for (int i = 0; i < NO; i++) begin
      if (ocpFault)                    v[i] = stopOcp[i];
      else if (enableIn != enablePol)  v[i] = stopDis[i];
      else if (bypassSel[i])           v[i] = bypassVal[i];
      else if (term)                   v[i] = 1'b0;
      else v[i] = (c >= actRise[i]) && (c < actFall[i] + actDuty);
    end
    return v;
  endfunction

  // Called at a falling edge where cycleStart is high; checks one whole period.
  task automatic runPeriod(input string req, input int termAt, input int chgAt, input int newDuty);
    for (int k = 1; k <= P + 1; k++) begin
      termReq = (k == termAt);
      if (k == chgAt) begin
        dutyB = newDuty;
        drivePorts();
      end
      @(negedge clk);
      chk(req, int'(phOut), int'(expVec(k - 1, (termAt > 0) && (k >= termAt))));
      chk("R9", int'(cycleStart), (k == P + 1) ? 1 : 0);
    end
    termReq = 1'b0;
    latchActive();
  endtask

  task automatic waitStart();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cycleStart && n < 2000);
  endtask

  task automatic measure(input int divider);
    int n = 0;
    waitStart();
    waitStart();
    do begin
      @(negedge clk);
      n++;
    end while (!cycleStart && n < 2000);
    chk("R1", n, (P + 1) * divider);
  endtask

  initial begin
    rstN = 1'b0;
    speedSel = 2'b00;
    periodLen = CW'(P);
    syncIn = 1'b1;
    enableIn = 1'b1;
    enablePol = 1'b1;
    ocpFault = 1'b0;
    termReq = 1'b0;
    bypassSel = '0;
    bypassVal = '0;
    stopDis = 6'b010110;
    stopOcp = 6'b101001;
    for (int i = 0; i < NO; i++) begin
      riseB[i] = i;
      fallB[i] = 2 * i;
    end
    dutyB = 4;
    drivePorts();
    repeat (3) @(negedge clk);
    chk("R10", int'(phOut), 0);
    chk("R10", int'(cycleStart), 0);
    rstN = 1'b1;
    waitStart();
    latchActive();

    // R7 / R8: duty sweep; each new duty is applied mid-period
    for (int d = 0; d <= P + 2; d++) begin
      runPeriod("R8", 0, 5, d);
    end
    runPeriod("R7", 0, 0, 0);

    // R7: second edge set, fall offsets large so the sum needs the extra bit
    for (int i = 0; i < NO; i++) begin
      riseB[i] = 2 * i + 1;
      fallB[i] = 100 * i;
    end
    fallB[NO-1] = 510;
    dutyB = 3;
    drivePorts();
    runPeriod("R8", 0, 0, 0);
    runPeriod("R7", 0, 0, 0);
    dutyB = 9;
    drivePorts();
    runPeriod("R8", 0, 0, 0);
    runPeriod("R7", 0, 0, 0);

    // R6: terminate, then a clean period
    runPeriod("R6", 6, 0, 0);
    runPeriod("R6", 0, 0, 0);

    // R5: bypass, with a terminate that must not touch the bypassed outputs
    bypassSel = 6'b100101;
    bypassVal = 6'b000100;
    runPeriod("R5", 4, 0, 0);
    bypassSel = '0;
    runPeriod("R5", 0, 0, 0);

    // R3: enable polarity
    enableIn = 1'b0;
    runPeriod("R3", 0, 0, 0);
    enablePol = 1'b0;
    runPeriod("R3", 0, 0, 0);
    enableIn = 1'b1;
    runPeriod("R3", 3, 0, 0);
    enablePol = 1'b1;

    // R4: fault wins over disable and terminate
    ocpFault = 1'b1;
    runPeriod("R4", 2, 0, 0);
    enableIn = 1'b0;
    bypassSel = 6'b111111;
    runPeriod("R4", 0, 0, 0);
    ocpFault = 1'b0;
    enableIn = 1'b1;
    bypassSel = '0;
    runPeriod("R4", 0, 0, 0);

    // R2: two low steps do not qualify
    syncIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    syncIn = 1'b1;
    @(negedge clk);
    chk("R2", int'(cycleStart), 0);
    begin
      int n = 3;
      do begin
        @(negedge clk);
        n++;
      end while (!cycleStart && n < 200);
      chk("R2", n, P + 1);
    end
    // R2: three low steps qualify, restart on the next sample
    syncIn = 1'b0;
    repeat (3) @(negedge clk);
    syncIn = 1'b1;
    @(negedge clk);
    chk("R2", int'(cycleStart), 1);
    runPeriod("R2", 0, 0, 0);

    // R1: prescale settings
    speedSel = 2'b01;
    measure(4);
    speedSel = 2'b10;
    measure(8);
    speedSel = 2'b11;
    measure(8);
    speedSel = 2'b00;
    measure(1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule